// File: doc/BRIEF.md
# Audio Master-Clock to Frame-Clock Ratio Detector

This block measures how many master-clock cycles fit into one period of an audio frame clock and reports which of seven oversampling ratios is in use. A downstream clock divider or converter rate stage uses the result. The seven ratios are 128, 192, 256, 384, 512, 768 and 1152. Each is accepted within a small tolerance, so a jittery or slightly off-nominal frame clock still resolves to the right ratio.

The frame clock that is measured depends on where the converter data comes from. The candidates are the frame clock of the primary serial audio port, the frame clock of the secondary serial audio port, and the sub-frame clock of the S/PDIF receiver. A receiver-to-converter mode bit forces the primary port's frame clock to be the reference, even when the route selects S/PDIF. All three candidates are synchronised into the master-clock domain. Rising edges of the chosen clock bound each counting window.

A ratio is declared valid only when two back-to-back periods give the same classification. A period that matches no ratio sets the error flag, and so does a frame clock that stops long enough to saturate the counter.

Top module: `frm_ratio_det`

## Requirements
- R1: A measured period of P master-clock cycles is classified as code 0..6 for the ratios 128, 192, 256, 384, 512, 768 and 1152, in that order, when |P - ratio| <= 2. For example, 130 and 190 are accepted and 131 is not.
- R2: The reference frame clock is chosen by `routeSel` when `rxToDacMode` is 0: 2'b00 and 2'b11 select `priFrame`, 2'b01 selects `secFrame`, and 2'b10 selects `spdifFrame`. Frame clocks that are not selected have no effect on the outputs.
- R3: While `rxToDacMode` is 1, `priFrame` is the reference for every value of `routeSel`.
- R4: `ratioValid` rises only when two consecutive complete periods give the same code. `ratioCode` changes only at that moment, and at other times it holds the last code that was valid.
- R5: A period whose code differs from the previous period's code clears `ratioValid` and leaves `ratioCode` unchanged.
- R6: A period that matches no ratio sets `ratioErr`, clears `ratioValid` and discards the period history. The next period that matches a ratio clears `ratioErr`.
- R7: If 2047 master-clock cycles pass after a counted rising edge with no further edge, the counter saturates. `ratioErr` is then set and `ratioValid` is cleared, without waiting for the next edge.
- R8: A change of the effective reference clears `ratioValid` and the history. Edges during the next 3 cycles are ignored. The first edge after that only opens a window, so valid returns no sooner than the third edge.
- R9: During reset and right after it, `ratioValid`, `ratioErr` and `ratioCode` are 0.
- R10: Each frame clock passes through a two-flop synchroniser. The measured period is the number of master-clock cycles between successive synchronised rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master audio clock |
| rstN | input | 1 | Active-low reset, synchronous to `clk` |
| priFrame | input | 1 | Primary serial port frame clock (asynchronous) |
| secFrame | input | 1 | Secondary serial port frame clock (asynchronous) |
| spdifFrame | input | 1 | S/PDIF receiver sub-frame clock (asynchronous) |
| routeSel | input | 2 | Data route to the converter: 00/11 primary, 01 secondary, 10 S/PDIF |
| rxToDacMode | input | 1 | Forces the primary frame clock to be the reference |
| ratioCode | output | 3 | Ratio code 0..6 (128..1152) |
| ratioValid | output | 1 | Two matching consecutive periods seen |
| ratioErr | output | 1 | Last period out of tolerance, or counter saturated |

## Verification
The assertions check on every cycle that:
- valid and error are never high together;
- a valid code lies in 0..6;
- the code changes only as valid rises, and valid rises only on an accepted edge;
- a change of reference drops valid in the next cycle;
- the saturated counter holds, and saturation raises the error.

Only the bench scenarios can show the rest:
- the tolerance boundaries (130 accepted, 131 and 1155 rejected);
- that the right candidate clock is measured while the others carry a foreign rate;
- that the mode bit overrides the S/PDIF route;
- that the overflow error appears in the middle of a stalled frame clock.

// File: rtl/frm_ratio_pkg.sv
package frm_ratio_pkg;

  localparam int NUM_RATIOS = 7;
  localparam int CODE_W     = 3;
  localparam int NUM_SRC    = 3;

  typedef enum logic [1:0] {
    SRC_PRI   = 2'd0,
    SRC_SEC   = 2'd1,
    SRC_SPDIF = 2'd2
  } srcSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClear;
    logic cntRun;
  } dpCtrl_t;

  // nominal master-clock cycles per frame for each code, ascending
  function automatic int ratioOf(input int idx);
    case (idx)
      0:       return 128;
      1:       return 192;
      2:       return 256;
      3:       return 384;
      4:       return 512;
      5:       return 768;
      default: return 1152;
    endcase
  endfunction

endpackage

// File: rtl/frm_sync.sv
module frm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] shiftQ;

  always_ff @(posedge clk) begin
    if (!rstN) shiftQ <= '0;
    else       shiftQ <= {shiftQ[STAGES-2:0], asyncIn};
  end

  assign syncOut = shiftQ[STAGES-1];

endmodule

// File: rtl/frm_ratio_dp.sv
module frm_ratio_dp
  import frm_ratio_pkg::*;
#(
  parameter int CNT_W       = 11,
  parameter int TOL         = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] frameIn,
  input  srcSel_e            srcSel,
  input  dpCtrl_t            ctl,
  output logic               frameRise,
  output logic               cntSat,
  output logic               classOk,
  output logic [CODE_W-1:0]  classCode
);

  localparam int LEN_W = CNT_W + 1;

  logic [NUM_SRC-1:0] frameSync;
  logic               selSync;
  logic               prevQ;
  logic [CNT_W-1:0]   cntQ;
  logic [LEN_W-1:0]   periodLen;
  logic [NUM_RATIOS-1:0] hit;

  // one synchroniser per candidate frame clock
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_sync
    frm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rstN    (rstN),
      .asyncIn (frameIn[s]),
      .syncOut (frameSync[s])
    );
  end

  always_comb begin
    case (srcSel)
      SRC_SEC:   selSync = frameSync[1];
      SRC_SPDIF: selSync = frameSync[2];
      default:   selSync = frameSync[0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= selSync;
  end

  assign frameRise = selSync & ~prevQ;

  // period counter, saturating
  assign cntSat = &cntQ;

  always_ff @(posedge clk) begin
    if (!rstN)                      cntQ <= '0;
    else if (ctl.cntClear)          cntQ <= '0;
    else if (ctl.cntRun && !cntSat) cntQ <= cntQ + CNT_W'(1);
  end

  assign periodLen = {1'b0, cntQ} + LEN_W'(1);

  // tolerance window compare against every supported ratio
  for (genvar i = 0; i < NUM_RATIOS; i++) begin : g_cls
    localparam int RATIO = ratioOf(i);
    assign hit[i] = (int'(periodLen) >= RATIO - TOL) &&
                    (int'(periodLen) <= RATIO + TOL);
  end

  always_comb begin
    classCode = '0;
    for (int i = NUM_RATIOS - 1; i >= 0; i--) begin
      if (hit[i]) classCode = CODE_W'(i);
    end
  end

  assign classOk = |hit;

  AST_CNT_HOLDS_AT_MAX: assert property (@(posedge clk) disable iff (!rstN)
    cntSat && !ctl.cntClear |=> cntSat); // R7

  AST_RISE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    frameRise |=> !frameRise); // R10

endmodule

// File: rtl/frm_ratio_ctrl.sv
module frm_ratio_ctrl
  import frm_ratio_pkg::*;
#(
  parameter int SETTLE_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        routeSel,
  input  logic              rxToDacMode,
  input  logic              frameRise,
  input  logic              cntSat,
  input  logic              classOk,
  input  logic [CODE_W-1:0] classCode,
  output srcSel_e           srcSel,
  output dpCtrl_t           ctl,
  output logic [CODE_W-1:0] ratioCode,
  output logic              ratioValid,
  output logic              ratioErr
);

  localparam int SETTLE_W = $clog2(SETTLE_CYC + 1);
  localparam logic [SETTLE_W-1:0] SETTLE_INIT = SETTLE_W'(SETTLE_CYC);

  srcSel_e             srcQ;
  logic                selChanged;
  logic [SETTLE_W-1:0] settleQ;
  logic                edgeSeen;
  logic                armedQ;
  logic                haveLastQ;
  logic [CODE_W-1:0]   lastCodeQ;
  logic                validQ;
  logic                errQ;
  logic [CODE_W-1:0]   codeQ;

  // effective reference selection
  always_comb begin
    if (rxToDacMode) begin
      srcSel = SRC_PRI;
    end else begin
      case (routeSel)
        2'b01:   srcSel = SRC_SEC;
        2'b10:   srcSel = SRC_SPDIF;
        default: srcSel = SRC_PRI;
      endcase
    end
  end

  assign selChanged = (srcSel != srcQ);
  assign edgeSeen   = frameRise && (settleQ == '0) && !selChanged;

  assign ctl.cntClear = edgeSeen || selChanged;
  assign ctl.cntRun   = armedQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcQ      <= SRC_PRI;
      settleQ   <= SETTLE_INIT;
      armedQ    <= 1'b0;
      haveLastQ <= 1'b0;
      lastCodeQ <= '0;
      validQ    <= 1'b0;
      errQ      <= 1'b0;
      codeQ     <= '0;
    end else begin
      srcQ <= srcSel;
      if (selChanged) begin
        settleQ   <= SETTLE_INIT;
        armedQ    <= 1'b0;
        haveLastQ <= 1'b0;
        validQ    <= 1'b0;
      end else begin
        if (settleQ != '0) settleQ <= settleQ - SETTLE_W'(1);
        if (edgeSeen) begin
          if (!armedQ) begin
            armedQ <= 1'b1;
          end else if (cntSat || !classOk) begin
            errQ      <= 1'b1;
            validQ    <= 1'b0;
            haveLastQ <= 1'b0;
          end else begin
            errQ      <= 1'b0;
            lastCodeQ <= classCode;
            haveLastQ <= 1'b1;
            if (haveLastQ && (classCode == lastCodeQ)) begin
              validQ <= 1'b1;
              codeQ  <= classCode;
            end else begin
              validQ <= 1'b0;
            end
          end
        end else if (armedQ && cntSat) begin
          errQ      <= 1'b1;
          validQ    <= 1'b0;
          haveLastQ <= 1'b0;
        end
      end
    end
  end

  assign ratioCode  = codeQ;
  assign ratioValid = validQ;
  assign ratioErr   = errQ;

  AST_VALID_EXCLUDES_ERR: assert property (@(posedge clk) disable iff (!rstN)
    !(validQ && errQ)); // R6

  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    validQ |-> (codeQ < CODE_W'(NUM_RATIOS))); // R1

  AST_CODE_MOVES_WITH_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(codeQ) |-> $rose(validQ)); // R4

  AST_VALID_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(validQ) |-> $past(edgeSeen)); // R4

  AST_RESTART_DROPS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    selChanged |=> !validQ); // R8

  AST_SAT_RAISES_ERR: assert property (@(posedge clk) disable iff (!rstN)
    armedQ && cntSat && !selChanged |=> errQ); // R7

endmodule

// File: rtl/frm_ratio_det.sv
module frm_ratio_det
  import frm_ratio_pkg::*;
#(
  parameter int CNT_W       = 11,
  parameter int TOL         = 2,
  parameter int SETTLE_CYC  = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              priFrame,
  input  logic              secFrame,
  input  logic              spdifFrame,
  input  logic [1:0]        routeSel,
  input  logic              rxToDacMode,
  output logic [CODE_W-1:0] ratioCode,
  output logic              ratioValid,
  output logic              ratioErr
);

  srcSel_e           srcSel;
  dpCtrl_t           ctl;
  logic              frameRise;
  logic              cntSat;
  logic              classOk;
  logic [CODE_W-1:0] classCode;

  frm_ratio_dp #(
    .CNT_W       (CNT_W),
    .TOL         (TOL),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .frameIn   ({spdifFrame, secFrame, priFrame}),
    .srcSel    (srcSel),
    .ctl       (ctl),
    .frameRise (frameRise),
    .cntSat    (cntSat),
    .classOk   (classOk),
    .classCode (classCode)
  );

  frm_ratio_ctrl #(
    .SETTLE_CYC (SETTLE_CYC)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .routeSel    (routeSel),
    .rxToDacMode (rxToDacMode),
    .frameRise   (frameRise),
    .cntSat      (cntSat),
    .classOk     (classOk),
    .classCode   (classCode),
    .srcSel      (srcSel),
    .ctl         (ctl),
    .ratioCode   (ratioCode),
    .ratioValid  (ratioValid),
    .ratioErr    (ratioErr)
  );

endmodule

// File: tb/frm_ratio_det_tb.sv
module frm_ratio_det_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] routeSel = 2'b00;
  logic       rxToDacMode = 1'b0;
  logic       genWave = 1'b0;
  logic       noiseWave = 1'b0;
  int         activeLine = 0;
  logic       priFrame, secFrame, spdifFrame;
  logic [2:0] ratioCode;
  logic       ratioValid, ratioErr;

  always #4 clk = ~clk; // 125 MHz

  assign priFrame   = (activeLine == 0) ? genWave : noiseWave;
  assign secFrame   = (activeLine == 1) ? genWave : noiseWave;
  assign spdifFrame = (activeLine == 2) ? genWave : noiseWave;

  frm_ratio_det u_dut (
    .clk(clk), .rstN(rstN), .priFrame(priFrame), .secFrame(secFrame),
    .spdifFrame(spdifFrame), .routeSel(routeSel), .rxToDacMode(rxToDacMode),
    .ratioCode(ratioCode), .ratioValid(ratioValid), .ratioErr(ratioErr)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // scoreboard: expected output triples {valid, code, err}
  logic [4:0] expQ[$];
  string      reqQ[$];

  // model state
  bit   mArmed = 0, mHave = 0, mValid = 0, mErr = 0;
  int   mLast = 0, mCode = 0;
  logic [4:0] mPub = 5'b0;
  int   pendLen = 0;
  int   mSrc = 0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int classify(int p);
    int tbl[7] = '{128, 192, 256, 384, 512, 768, 1152};
    for (int i = 0; i < 7; i++)
      if (p >= tbl[i] - 2 && p <= tbl[i] + 2) return i;
    return -1;
  endfunction

  function automatic int effSrc(logic [1:0] rs, logic md);
    if (md) return 0;
    if (rs == 2'b01) return 1;
    if (rs == 2'b10) return 2;
    return 0;
  endfunction

  task automatic publish(string req);
    logic [4:0] cur;
    cur = {mValid, 3'(mCode), mErr};
    if (cur != mPub) begin
      expQ.push_back(cur);
      reqQ.push_back(req);
      mPub = cur;
    end
  endtask

  task automatic modelRise(int p, string req);
    int c;
    if (!mArmed) begin mArmed = 1; return; end
    c = (p >= 2048) ? -1 : classify(p);
    if (c < 0) begin
      mErr = 1; mValid = 0; mHave = 0;
    end else begin
      mErr = 0;
      if (mHave && c == mLast) begin mValid = 1; mCode = c; end
      else mValid = 0;
      mLast = c; mHave = 1;
    end
    publish(req);
  endtask

  // periods of p cycles on the generated line, each starting with a rise
  task automatic genPeriods(int p, int n, string req);
    for (int k = 0; k < n; k++) begin
      modelRise(pendLen, req);
      genWave = 1'b1;
      repeat (p / 2) @(negedge clk);
      genWave = 1'b0;
      repeat (p - p / 2) @(negedge clk);
      pendLen = p;
    end
  endtask

  task automatic setRoute(logic [1:0] rs, logic md, int line, string req);
    int ns;
    ns = effSrc(rs, md);
    routeSel = rs; rxToDacMode = md; activeLine = line;
    if (ns != mSrc) begin
      mSrc = ns; mArmed = 0; mHave = 0; mValid = 0;
      publish(req);
      repeat (8) @(negedge clk);
    end
  endtask

  // noise on the lines that are not the intended reference
  initial begin
    forever begin
      repeat (35) @(negedge clk);
      noiseWave = ~noiseWave;
    end
  end

  // monitor: every output change must match the next expected item
  logic [4:0] seen = 5'b0;
  always @(negedge clk) begin
    if (rstN && !done) begin
      logic [4:0] cur;
      cur = {ratioValid, ratioCode, ratioErr};
      if (cur !== seen) begin
        checks++;
        if (expQ.size() == 0) begin
          errors++;
          $display("FAIL unexpected output change actual=%b expected=%b", cur, seen);
        end else begin
          logic [4:0] e;
          string r;
          e = expQ.pop_front();
          r = reqQ.pop_front();
          if (cur !== e) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", r, cur, e);
          end
        end
        seen = cur;
      end
    end
  end

  // watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    check("R9 valid in reset", int'(ratioValid), 0);
    check("R9 err in reset", int'(ratioErr), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 code after reset", int'(ratioCode), 0);
    repeat (5) @(negedge clk);

    genPeriods(128, 4, "R1 R4 R10 ratio 128");
    genPeriods(130, 3, "R1 upper tolerance 130");
    genPeriods(131, 2, "R6 out of tolerance 131");
    genPeriods(190, 3, "R6 R1 error clear and 190");
    check("R1 code for 190", int'(ratioCode), 1);
    genPeriods(256, 3, "R1 ratio 256");
    genPeriods(384, 3, "R5 R1 ratio change 384");
    genPeriods(512, 3, "R1 ratio 512");
    genPeriods(768, 3, "R1 ratio 768");
    genPeriods(1152, 3, "R1 ratio 1152");
    genPeriods(1154, 2, "R1 tolerance 1154");
    genPeriods(1155, 2, "R6 out of tolerance 1155");
    genPeriods(256, 3, "R6 recovery 256");

    // counter saturation with the frame clock stalled
    modelRise(pendLen, "R7 rise before stall");
    genWave = 1'b1;
    repeat (10) @(negedge clk);
    genWave = 1'b0;
    mErr = 1; mValid = 0; mHave = 0;
    publish("R7 overflow");
    repeat (2060) @(negedge clk);
    check("R7 err during stall", int'(ratioErr), 1);
    check("R7 valid during stall", int'(ratioValid), 0);
    repeat (10) @(negedge clk);
    pendLen = 2080;
    genPeriods(384, 3, "R7 recovery 384");

    // routing selections with noise on the other lines
    setRoute(2'b01, 1'b0, 1, "R8 switch to secondary");
    check("R8 valid dropped on switch", int'(ratioValid), 0);
    genPeriods(256, 2, "R2 R8 secondary first windows");
    check("R8 no valid before third edge", int'(ratioValid), 0);
    genPeriods(256, 1, "R2 secondary 256");
    setRoute(2'b10, 1'b0, 2, "R8 switch to spdif");
    genPeriods(768, 3, "R2 spdif 768");
    setRoute(2'b11, 1'b0, 0, "R8 switch to primary by 11");
    genPeriods(512, 3, "R2 primary via 11");
    setRoute(2'b10, 1'b1, 0, "R3 mode keeps primary");
    genPeriods(512, 2, "R3 mode forces primary");
    check("R3 valid under mode", int'(ratioValid), 1);
    check("R3 code under mode", int'(ratioCode), 4);

    repeat (30) @(negedge clk);
    check("R4 all expected changes seen", expQ.size(), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule